// File: doc/BRIEF.md
# Launch-Committed Message Port

This block sits between a processor's register bus and a flit network. Software composes an outgoing message by writing words into a staging file. Nothing leaves the port while it does so. A single launch command commits the whole message, and the port then streams it out as a run of flits, each marked as head, body or tail. A message is therefore either fully handed to the network or not started. Because the staging file can be read back, a half-built message can be saved and restored across a context switch.

On the receive side, arriving flits are gathered into message slots. The oldest complete message is presented to software, which reads its words by index and releases it with a dispose command. Its arrival is signalled by a maskable interrupt line and also by a status bit that can be polled. Further complete messages wait in the remaining slots. Masking the interrupt does not stop the port from accepting input while a slot is free.

Top module: `msg_nic`

## Requirements
- R1: After reset the status word, the staging words and the flit output are all zero or idle, the interrupt is low and `rx_ready` is high. A bus write to address 0x00+i (i = 0..15) stores staging word i, and a read of that address returns it.
- R2: Writing staging words never produces a flit. `tx_valid` stays low until a launch is issued, which is a command write to 0x10 with bit 0 set.
- R3: A launch sends L flits, where L is the length field in bits [5:0] of staging word 0. The flits carry staging words 0..L-1 in order. `tx_kind` bit 0 marks the first flit, bit 1 marks the last, and a one-flit message has both bits set. While `tx_ready` is low, the flit and its kind hold steady.
- R4: A launch whose length is 0 or greater than 16 sends nothing and sets the error bit, status bit 1. A command write with bit 2 set clears it.
- R5: Status bit 0 reads 1 while a message is streaming. During that time, staging writes and further launches are ignored.
- R6: Status bit 2 is set while a received message is present. Status bits [12:8] give its word count, and a read of 0x20+i returns its word i.
- R7: The `irq` output is high exactly when the enable bit (bit 0 at address 0x11) is set and a received message is present. Input is still accepted while that bit is clear.
- R8: The port holds one presented message plus two pending ones. `rx_ready` falls only when all three slots hold complete messages.
- R9: A dispose (command bit 1) releases the presented message and brings the next pending message forward. If a message remains, the interrupt stays asserted.
- R10: A dispose with no message present changes nothing. Status remains empty, and later messages are received and read correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| tx_valid | output | 1 | Outgoing flit valid |
| tx_ready | input | 1 | Network accepts outgoing flit |
| tx_data | output | 32 | Outgoing flit word |
| tx_kind | output | 2 | Outgoing flit marks: bit 0 head, bit 1 tail |
| rx_valid | input | 1 | Incoming flit valid |
| rx_ready | output | 1 | Port accepts incoming flit |
| rx_data | input | 32 | Incoming flit word |
| rx_kind | input | 2 | Incoming flit marks: bit 0 head, bit 1 tail |
| irq | output | 1 | Message-present interrupt |

## Verification
Outgoing messages of three, one and sixteen flits are launched, with the network ready held high for some and toggling for others. These runs separate correct head and tail marking and word order from errors that only appear under stalls. Launches with lengths 0 and 17 show whether the length check is done before any flit is sent. On the receive side, three messages arrive back to back with the interrupt masked, then are disposed one by one. This sequence shows slot ordering, the full-port backpressure point, and the interrupt coming back on unmask. A final dispose on an empty port is followed by a fresh message, which exposes any pointer or count that the ignored command disturbed.

// File: rtl/msg_nic_pkg.sv
package msg_nic_pkg;
  localparam int DW     = 32;
  localparam int SW     = 16;
  localparam int LENW   = 6;
  localparam int IDXW   = $clog2(SW);
  localparam int CNTW   = $clog2(SW + 1);

  // length field of a header word
  function automatic logic [LENW-1:0] hdr_len(input logic [DW-1:0] w);
    return w[LENW-1:0];
  endfunction

  function automatic logic len_ok(input logic [LENW-1:0] n);
    return (n != '0) && (n <= LENW'(SW));
  endfunction

  // {tail, head} marks for flit idx of an n-flit message
  function automatic logic [1:0] flit_kind(input logic [CNTW-1:0] idx,
                                           input logic [CNTW-1:0] n);
    return {idx == n - CNTW'(1), idx == '0};
  endfunction
endpackage

// File: rtl/nic_tx.sv
module nic_tx
  import msg_nic_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [DW-1:0]   wr_data,
  input  logic [IDXW-1:0] rd_idx,
  output logic [DW-1:0]   rd_data,
  input  logic            launch,
  input  logic            clr_err,
  output logic            busy,
  output logic            err,
  output logic            tx_valid,
  input  logic            tx_ready,
  output logic [DW-1:0]   tx_data,
  output logic [1:0]      tx_kind
);
  logic [DW-1:0]   stage [SW];
  logic [CNTW-1:0] idx, len;
  logic [LENW-1:0] req_len;
  logic            wr_take, wr_blocked, launch_good, launch_bad, fire, last;

  assign req_len     = hdr_len(stage[0]);
  assign wr_take     = wr_en && !busy;
  assign wr_blocked  = wr_en && busy;
  assign launch_good = launch && !busy && len_ok(req_len);
  assign launch_bad  = launch && !busy && !len_ok(req_len);
  assign tx_valid    = busy;
  assign tx_data     = stage[idx[IDXW-1:0]];
  assign tx_kind     = flit_kind(idx, len);
  assign fire        = tx_valid && tx_ready;
  assign last        = tx_kind[1];
  assign rd_data     = stage[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SW; i++) stage[i] <= '0;
      busy <= 1'b0;
      err  <= 1'b0;
      idx  <= '0;
      len  <= '0;
    end else begin
      if (wr_take) stage[wr_idx] <= wr_data;
      if (clr_err) err <= 1'b0;
      if (launch_bad) err <= 1'b1;
      if (launch_good) begin
        busy <= 1'b1;
        idx  <= '0;
        len  <= CNTW'(req_len);
      end else if (fire) begin
        if (last) busy <= 1'b0;
        else      idx  <= idx + CNTW'(1);
      end
    end
  end

  logic [DW-1:0] wr_old;
  assign wr_old = stage[wr_idx];

  p_flit_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_kind)));
  p_bad_launch_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    launch_bad |=> (!tx_valid && err));
  p_stage_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_blocked |=> (stage[$past(wr_idx)] == $past(wr_old)));
endmodule

// File: rtl/nic_rx.sv
module nic_rx
  import msg_nic_pkg::*;
#(
  parameter int PEND = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rx_valid,
  output logic            rx_ready,
  input  logic [DW-1:0]   rx_data,
  input  logic [1:0]      rx_kind,
  input  logic            dispose,
  input  logic [IDXW-1:0] rd_idx,
  output logic [DW-1:0]   rd_data,
  output logic            avail,
  output logic [CNTW-1:0] cur_len
);
  localparam int NSLOT = PEND + 1;
  localparam int PW    = (NSLOT > 1) ? $clog2(NSLOT) : 1;
  localparam int QW    = $clog2(NSLOT + 1);

  logic [DW-1:0]   mem  [NSLOT][SW];
  logic [CNTW-1:0] mlen [NSLOT];
  logic [PW-1:0]   wp, rp;
  logic [QW-1:0]   cnt;
  logic [CNTW-1:0] widx, pos, nwords;
  logic            take, msg_done, disp_do;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(NSLOT - 1)) ? '0 : p + PW'(1);
  endfunction

  assign rx_ready = cnt < QW'(NSLOT);
  assign take     = rx_valid && rx_ready;
  assign pos      = rx_kind[0] ? '0 : widx;
  assign nwords   = (pos < CNTW'(SW)) ? pos + CNTW'(1) : CNTW'(SW);
  assign msg_done = take && rx_kind[1];
  assign disp_do  = dispose && (cnt != '0);
  assign avail    = cnt != '0;
  assign cur_len  = avail ? mlen[rp] : '0;
  assign rd_data  = avail ? mem[rp][rd_idx] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NSLOT; s++) begin
        mlen[s] <= '0;
        for (int i = 0; i < SW; i++) mem[s][i] <= '0;
      end
      wp <= '0; rp <= '0; cnt <= '0; widx <= '0;
    end else begin
      if (take) begin
        if (pos < CNTW'(SW)) mem[wp][pos[IDXW-1:0]] <= rx_data;
        widx <= nwords;
      end
      if (msg_done) begin
        mlen[wp] <= nwords;
        wp   <= bump(wp);
        widx <= '0;
      end
      if (disp_do) rp <= bump(rp);
      cnt <= cnt + QW'(msg_done) - QW'(disp_do);
    end
  end

  p_msg_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_done && !disp_do) |=> (cnt == $past(cnt) + QW'(1)));
  p_idle_dispose_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dispose && !avail && !msg_done) |=> (!avail && rp == $past(rp)));
endmodule

// File: rtl/msg_nic.sv
module msg_nic
  import msg_nic_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [5:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [31:0] tx_data,
  output logic [1:0]  tx_kind,
  input  logic        rx_valid,
  output logic        rx_ready,
  input  logic [31:0] rx_data,
  input  logic [1:0]  rx_kind,
  output logic        irq
);
  localparam logic [5:0] A_CMD  = 6'h10;
  localparam logic [5:0] A_CTRL = 6'h11;

  logic            sel_stage, sel_rx, cmd_wr;
  logic            busy, err, avail, irq_en;
  logic [DW-1:0]   stage_rd, rx_rd;
  logic [CNTW-1:0] cur_len;

  assign sel_stage = bus_addr[5:4] == 2'b00;
  assign sel_rx    = bus_addr[5:4] == 2'b10;
  assign cmd_wr    = bus_we && (bus_addr == A_CMD);

  nic_tx u_tx (
    .clk(clk), .rst_n(rst_n),
    .wr_en(bus_we && sel_stage), .wr_idx(bus_addr[IDXW-1:0]), .wr_data(bus_wdata),
    .rd_idx(bus_addr[IDXW-1:0]), .rd_data(stage_rd),
    .launch(cmd_wr && bus_wdata[0]), .clr_err(cmd_wr && bus_wdata[2]),
    .busy(busy), .err(err),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_kind(tx_kind)
  );

  nic_rx #(.PEND(2)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_kind(rx_kind),
    .dispose(cmd_wr && bus_wdata[1]),
    .rd_idx(bus_addr[IDXW-1:0]), .rd_data(rx_rd),
    .avail(avail), .cur_len(cur_len)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_en <= 1'b0;
    else if (bus_we && bus_addr == A_CTRL) irq_en <= bus_wdata[0];
  end

  assign irq = irq_en && avail;

  always_comb begin
    bus_rdata = '0;
    if (sel_stage)               bus_rdata = stage_rd;
    else if (sel_rx)             bus_rdata = rx_rd;
    else if (bus_addr == A_CMD)  bus_rdata = {19'd0, cur_len, 5'd0, avail, err, busy};
    else if (bus_addr == A_CTRL) bus_rdata = {31'd0, irq_en};
  end

  p_irq_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_CTRL && !bus_wdata[0]) |=> !irq);
endmodule

// File: tb/msg_nic_tb.sv
module msg_nic_tb;
  logic        clk = 0, rst_n = 0;
  logic        bus_we = 0;
  logic [5:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic        tx_valid, tx_ready = 1, rx_ready, irq;
  logic [31:0] tx_data, rx_data = 0;
  logic [1:0]  tx_kind, rx_kind = 0;
  logic        rx_valid = 0;

  msg_nic u_dut (.*);

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit bp_en = 0;
  logic [33:0] exp_q [$];
  logic [31:0] sw_model [16];

  task automatic chk(input bit ok, input string req, input logic [33:0] act, input logic [33:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      finish_run();
    end
  end

  // monitor: scoreboard of outgoing flits (R3)
  always @(negedge clk) begin
    tx_ready = bp_en ? cyc[0] : 1'b1;
    #1;
    if (rst_n && tx_valid && tx_ready) begin
      if (exp_q.size() == 0)
        chk(0, "R2/R5 unexpected flit", {tx_kind, tx_data}, 34'h0);
      else begin
        logic [33:0] e;
        e = exp_q.pop_front();
        chk({tx_kind, tx_data} == e, "R3 flit", {tx_kind, tx_data}, e);
      end
    end
  end

  task automatic bus_wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic bus_rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #2;
    d = bus_rdata;
  endtask

  task automatic stage(input int i, input logic [31:0] d);
    bus_wr(6'(i), d);
    sw_model[i] = d;
  endtask

  // driver: push expected flits, then launch
  task automatic launch_expect(input int n);
    for (int i = 0; i < n; i++)
      exp_q.push_back({(i == n - 1), (i == 0), sw_model[i]});
    bus_wr(6'h10, 32'h1);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic send_msg(input int n, input logic [31:0] base);
    for (int i = 0; i < n; i++) begin
      bit done = 0;
      while (!done) begin
        @(negedge clk);
        rx_valid = 1; rx_data = base + 32'(i);
        rx_kind = {(i == n - 1), (i == 0)};
        #2;
        if (rx_ready) begin @(posedge clk); done = 1; end
      end
    end
    @(negedge clk);
    rx_valid = 0;
  endtask

  initial begin
    logic [31:0] r;
    for (int i = 0; i < 16; i++) sw_model[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    bus_rd(6'h10, r);
    chk(r == 0, "R1 status after reset", {2'b0, r}, 0);
    chk({tx_valid, irq, rx_ready} == 3'b001, "R1 outputs after reset", {31'b0, tx_valid, irq, rx_ready}, 1);
    bus_rd(6'h05, r);
    chk(r == 0, "R1 staging after reset", {2'b0, r}, 0);

    // R1/R2 staging write, readback, no flit
    stage(0, 32'h0000_0503);
    stage(1, 32'hA1A1_0001);
    stage(2, 32'hB2B2_0002);
    bus_rd(6'h01, r);
    chk(r == 32'hA1A1_0001, "R1 staging readback", {2'b0, r}, {2'b0, 32'hA1A1_0001});
    repeat (4) @(negedge clk);
    chk(!tx_valid, "R2 no flit before launch", {33'b0, tx_valid}, 0);

    // R3/R5 three-flit launch with backpressure
    bp_en = 1;
    launch_expect(3);
    bus_rd(6'h10, r);
    chk(r[0] == 1, "R5 busy while streaming", {33'b0, r[0]}, 1);
    bus_wr(6'h01, 32'hDEAD_BEEF);
    bus_wr(6'h10, 32'h1);
    drain();
    bus_rd(6'h01, r);
    chk(r == 32'hA1A1_0001, "R5 staging write ignored while busy", {2'b0, r}, {2'b0, 32'hA1A1_0001});
    bus_rd(6'h10, r);
    chk(r[1:0] == 0, "R5 idle after message", {32'b0, r[1:0]}, 0);

    // R3 single-flit message, marks both set
    bp_en = 0;
    stage(0, 32'h0000_0701);
    launch_expect(1);
    drain();

    // R3 sixteen-flit message with backpressure
    bp_en = 1;
    for (int i = 1; i < 16; i++) stage(i, 32'h1000_0000 + 32'(i));
    stage(0, 32'h0000_0910);
    launch_expect(16);
    drain();
    bp_en = 0;

    // R4 bad lengths
    stage(0, 32'h0000_0000);
    bus_wr(6'h10, 32'h1);
    repeat (3) @(negedge clk);
    bus_rd(6'h10, r);
    chk(r[1] == 1 && !tx_valid, "R4 length 0 rejected", {32'b0, r[1], tx_valid}, 2);
    bus_wr(6'h10, 32'h4);
    stage(0, 32'h0000_0011);
    bus_wr(6'h10, 32'h1);
    repeat (3) @(negedge clk);
    bus_rd(6'h10, r);
    chk(r[1] == 1 && !tx_valid, "R4 length 17 rejected", {32'b0, r[1], tx_valid}, 2);
    bus_wr(6'h10, 32'h4);
    bus_rd(6'h10, r);
    chk(r[1] == 0, "R4 error cleared", {33'b0, r[1]}, 0);

    // R6/R7 receive with interrupt enabled
    bus_wr(6'h11, 32'h1);
    send_msg(2, 32'h5000_0000);
    @(negedge clk);
    chk(irq == 1, "R7 irq on arrival", {33'b0, irq}, 1);
    bus_rd(6'h10, r);
    chk(r[2] == 1 && r[12:8] == 2, "R6 avail and length", {19'b0, r[12:8], 8'b0, r[2]}, {19'b0, 5'd2, 8'b0, 1'b1});
    bus_rd(6'h21, r);
    chk(r == 32'h5000_0001, "R6 word 1", {2'b0, r}, {2'b0, 32'h5000_0001});

    // R7/R8 masked, keep draining until full
    bus_wr(6'h11, 32'h0);
    chk(irq == 0, "R7 irq masked", {33'b0, irq}, 0);
    send_msg(3, 32'h6000_0000);
    chk(rx_ready == 1, "R8 ready with one slot free", {33'b0, rx_ready}, 1);
    send_msg(1, 32'h7000_0000);
    chk(rx_ready == 0, "R8 not ready when all slots full", {33'b0, rx_ready}, 0);

    // R9 dispose brings next forward, irq reasserts
    bus_wr(6'h10, 32'h2);
    bus_rd(6'h20, r);
    chk(r == 32'h6000_0000, "R9 next message word 0", {2'b0, r}, {2'b0, 32'h6000_0000});
    chk(rx_ready == 1, "R8 ready after dispose", {33'b0, rx_ready}, 1);
    bus_wr(6'h11, 32'h1);
    chk(irq == 1, "R9 irq with pending after dispose", {33'b0, irq}, 1);
    bus_wr(6'h10, 32'h2);
    bus_rd(6'h10, r);
    chk(r[12:8] == 1 && irq, "R9 third message length", {28'b0, r[12:8], irq}, {28'b0, 5'd1, 1'b1});
    bus_wr(6'h10, 32'h2);
    chk(irq == 0, "R7 irq low when empty", {33'b0, irq}, 0);

    // R10 dispose on empty ignored
    bus_wr(6'h10, 32'h2);
    bus_rd(6'h10, r);
    chk(r[2] == 0 && r[12:8] == 0, "R10 empty after idle dispose", {2'b0, r}, 0);
    send_msg(2, 32'h8000_0000);
    bus_rd(6'h20, r);
    chk(r == 32'h8000_0000, "R10 later message intact", {2'b0, r}, {2'b0, 32'h8000_0000});
    bus_rd(6'h10, r);
    chk(r[12:8] == 2, "R10 later message length", {29'b0, r[12:8]}, 2);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule